// File: doc/BRIEF.md
# CPU Clock Source Switch with Half-Step Divider

This block produces the processor clock. It picks one of two incoming clocks, a fixed-rate reference or a fast PLL output. It then divides the chosen clock by a ratio that can be set in steps of one half. Software sets both the source and the ratio with one 32-bit write to a single control word on a simple memory-mapped bus. The block applies the two together. It stops the old clock cleanly, loads the new setting while no clock edge reaches the divider, and then starts the new clock. The divider uses both edges of the chosen clock, so every output pulse lasts a whole number of input half-periods.

A busy flag in the control word stays set while an update is under way. A write that arrives while the flag is set waits and is applied after the current update ends. When the PLL is about to be retuned, a safe-mode request moves the output to the reference clock divided by two. The block ignores software writes while the request is high. The safe setting stays in place after the request drops, until software writes a new setting.

Top module: `cpuclk_mux_div`

## Requirements
- R1: After reset the control word reads source code 4 and divider value 3. Once busy clears, `cpu_clk` runs at the reference clock divided by two.
- R2: Only the word at byte offset 0x50 responds, which means `bus_addr[11:2]` equals 0x14. A write to any other offset changes nothing. A read from any other offset returns zero.
- R3: In the control word, bits [4:0] hold the divider value H, bits [10:8] hold the source code and bit 31 is the busy flag. All other bits read zero. A read returns the setting that is currently in effect.
- R4: For a divider value H, let N = max(H,1)+1. The output period is N half-periods of the chosen clock, and the output is high for floor(N/2) of them. H=0 behaves exactly like H=1, which is divide-by-one. The setting does not change while the divider is running.
- R5: Source code 4 selects `ref_clk`. Source code 5 selects `pll_clk`.
- R6: The busy flag reads 1 from the cycle after an accepted write until the new source and ratio are both in effect. It then reads 0.
- R7: A write made while busy is held back, not lost. After the current update ends, the most recent held write is applied, with its source and ratio together.
- R8: A write with a source code other than 4 or 5 stops `cpu_clk` at low. Read-back keeps the previous setting. A later valid write starts the clock again.
- R9: While `safe_req` is high, the block moves to source code 4 with divider value 3 and ignores software writes. That setting remains after `safe_req` falls, until the next write.
- R10: The source switch is glitch-free. The two source gates are never open at the same time, and no pulse on `cpu_clk` is shorter than one half-period of the faster source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Fixed-rate reference clock |
| pll_clk | input | 1 | PLL clock |
| safe_req | input | 1 | Request for the safe setting during PLL retune, synchronous to `clk` |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cpu_clk | output | 1 | Divided output clock |

## Verification
The assertions assume the following about the inputs:
- `safe_req` and the bus signals change only in step with `clk`.
- Both source clocks keep toggling, so every gate hand-off completes.

Under these assumptions, the assertions require that the two source gates are never acknowledged together and that the divider setting stays frozen while the divider runs. The bench drives all inputs on the falling edge of `clk`, keeps both source clocks running for the whole run, and draws random sources and divider values only from the legal codes. Invalid codes and safe-mode requests come only from directed cases.

// File: rtl/cksw_pkg.sv
`timescale 1ns/100ps
package cksw_pkg;
  localparam int unsigned  REG_AW     = 12;
  localparam int unsigned  REG_DW     = 32;
  localparam logic [11:0]  CFG_OFFSET = 12'h050;
  localparam int unsigned  DIV_W      = 5;
  localparam int unsigned  SRC_W      = 3;
  localparam int unsigned  DIV_LSB    = 0;
  localparam int unsigned  SRC_LSB    = 8;
  localparam logic [SRC_W-1:0] SRC_REF  = 3'd4;
  localparam logic [SRC_W-1:0] SRC_PLL  = 3'd5;
  localparam logic [DIV_W-1:0] SAFE_DIV = 5'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_STOP, ST_APPLY, ST_START} sw_state_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } cfg_t;
endpackage

// File: rtl/cksw_rsync.sv
`timescale 1ns/100ps
// Reset synchronizer: asserts at once, releases on the local clock.
module cksw_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cksw_gate.sv
`timescale 1ns/100ps
// One source gate: request synchronised into the source domain, enable
// flop on the falling edge so the gated clock stops and starts low,
// enable state synchronised back into the bus domain as acknowledge.
module cksw_gate #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic bus_rst_n,
  input  logic src_clk,
  input  logic rst_n,
  input  logic want,
  output logic gclk,
  output logic ack
);
  logic            src_rst_n;
  logic [SYNC-1:0] req_q;
  logic            en_q;
  logic [SYNC-1:0] ack_q;

  cksw_rsync #(.STAGES(2)) u_rs (.clk(src_clk), .rst_n(rst_n), .rst_n_sync(src_rst_n));

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) req_q <= '0;
    else            req_q <= {req_q[SYNC-2:0], want};
  end

  always_ff @(negedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) en_q <= 1'b0;
    else            en_q <= req_q[SYNC-1];
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) ack_q <= '0;
    else            ack_q <= {ack_q[SYNC-2:0], en_q};
  end

  assign gclk = src_clk & en_q;
  assign ack  = ack_q[SYNC-1];
endmodule

// File: rtl/cksw_hdiv.sv
`timescale 1ns/100ps
// Half-step divider. A half-period index advances on every edge; the
// rising-edge flops read the falling-edge state and vice versa. The
// output is the XOR of one flop per edge, so only one input changes
// at a time.
module cksw_hdiv #(
  parameter int unsigned DW = 5
) (
  input  logic          mclk,
  input  logic          clr_n,
  input  logic [DW-1:0] hval,
  output logic          clk_out
);
  logic [DW-1:0] lim, hi;
  logic [DW:0]   lim_p1;
  logic [DW-1:0] kp_q, kn_q, kp_nx, kn_nx;
  logic          op_q, on_q, dp, dn;

  always_comb begin
    lim    = (hval == '0) ? DW'(1) : hval;
    lim_p1 = {1'b0, lim} + 1'b1;
    hi     = lim_p1[DW:1];
    kp_nx  = (kn_q >= lim) ? '0 : kn_q + 1'b1;
    kn_nx  = (kp_q >= lim) ? '0 : kp_q + 1'b1;
    dp     = (kp_nx < hi);
    dn     = (kn_nx < hi);
  end

  always_ff @(posedge mclk or negedge clr_n) begin
    if (!clr_n) begin
      kp_q <= '0;
      op_q <= 1'b0;
    end else begin
      kp_q <= kp_nx;
      op_q <= dp ^ on_q;
    end
  end

  always_ff @(negedge mclk or negedge clr_n) begin
    if (!clr_n) begin
      kn_q <= '0;
      on_q <= 1'b0;
    end else begin
      kn_q <= kn_nx;
      on_q <= dn ^ op_q;
    end
  end

  assign clk_out = op_q ^ on_q;
endmodule

// File: rtl/cksw_ctrl.sv
`timescale 1ns/100ps
module cksw_ctrl
  import cksw_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned DW = REG_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             safe_req,
  input  logic             ack_ref,
  input  logic             ack_pll,
  output logic             want_ref,
  output logic             want_pll,
  output logic             div_run,
  output logic [DIV_W-1:0] act_div
);
  localparam logic [AW-1:0] OFS      = AW'(CFG_OFFSET);
  localparam int unsigned   BUSY_BIT = DW - 1;
  localparam cfg_t          SAFE_CFG = cfg_t'{src: SRC_REF, div: SAFE_DIV};

  sw_state_e st_q, st_nx;
  cfg_t      act_q, act_nx, pend_q, pend_nx, work_q, work_nx;
  logic      pend_v_q, pend_v_nx, dark_q, dark_nx, run_q, run_nx;
  logic      wref_q, wref_nx, wpll_q, wpll_nx, safe_q;
  logic      hit, safe_load, sw_load, take, busy, work_ok;
  logic      unused_bits;

  assign hit         = (bus_addr[AW-1:2] == OFS[AW-1:2]);
  assign safe_load   = safe_req & ~safe_q;
  assign sw_load     = bus_wr & hit & ~safe_req;
  assign take        = (st_q == ST_IDLE) & pend_v_q;
  assign busy        = pend_v_q | (st_q != ST_IDLE);
  assign work_ok     = (work_q.src == SRC_REF) | (work_q.src == SRC_PLL);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_comb begin
    st_nx = st_q;  act_nx = act_q;  pend_nx = pend_q;  pend_v_nx = pend_v_q;
    work_nx = work_q;  dark_nx = dark_q;  run_nx = run_q;
    wref_nx = wref_q;  wpll_nx = wpll_q;
    if (safe_load) begin
      pend_nx = SAFE_CFG;  pend_v_nx = 1'b1;
    end else if (sw_load) begin
      pend_nx.src = bus_wdata[SRC_LSB +: SRC_W];
      pend_nx.div = bus_wdata[DIV_LSB +: DIV_W];
      pend_v_nx   = 1'b1;
    end else if (take) begin
      pend_v_nx = 1'b0;
    end
    unique case (st_q)
      ST_IDLE: if (pend_v_q) begin
        work_nx = pend_q;  wref_nx = 1'b0;  wpll_nx = 1'b0;  st_nx = ST_STOP;
      end
      ST_STOP: if (!ack_ref && !ack_pll) begin
        run_nx = 1'b0;  st_nx = ST_APPLY;
      end
      ST_APPLY: if (work_ok) begin
        act_nx = work_q;  dark_nx = 1'b0;  run_nx = 1'b1;  st_nx = ST_START;
      end else begin
        dark_nx = 1'b1;  st_nx = ST_IDLE;
      end
      ST_START: begin
        wref_nx = (act_q.src == SRC_REF);
        wpll_nx = (act_q.src == SRC_PLL);
        if ((wref_q && ack_ref) || (wpll_q && ack_pll)) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_START;  act_q <= SAFE_CFG;  pend_q <= '0;  pend_v_q <= 1'b0;
      work_q <= '0;  dark_q <= 1'b0;  run_q <= 1'b1;
      wref_q <= 1'b0;  wpll_q <= 1'b0;  safe_q <= 1'b0;
    end else begin
      st_q <= st_nx;  act_q <= act_nx;  pend_q <= pend_nx;  pend_v_q <= pend_v_nx;
      work_q <= work_nx;  dark_q <= dark_nx;  run_q <= run_nx;
      wref_q <= wref_nx;  wpll_q <= wpll_nx;  safe_q <= safe_req;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[BUSY_BIT]           = busy;
      bus_rdata[SRC_LSB +: SRC_W]   = act_q.src;
      bus_rdata[DIV_LSB +: DIV_W]   = act_q.div;
    end
  end

  assign want_ref = wref_q;
  assign want_pll = wpll_q;
  assign div_run  = run_q;
  assign act_div  = act_q.div;

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> busy);                                                      // R6
  AST_SINGLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_ref && ack_pll));                                                 // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(act_q));                            // R4
  AST_SAFE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_q && safe_req && st_q == ST_IDLE && !pend_v_q) |-> (act_q == SAFE_CFG && !dark_q)); // R9
  AST_DARK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    dark_q |-> (!wref_q && !wpll_q));                                       // R8
endmodule

// File: rtl/cpuclk_mux_div.sv
`timescale 1ns/100ps
module cpuclk_mux_div
  import cksw_pkg::*;
#(
  parameter int unsigned AW   = REG_AW,
  parameter int unsigned DW   = REG_DW,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          pll_clk,
  input  logic          safe_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cpu_clk
);
  localparam int unsigned NSRC = 2;

  logic             bus_rst_n, div_run, mclk;
  logic [DIV_W-1:0] act_div;
  logic [NSRC-1:0]  src_vec, want_vec, ack_vec, gclk_vec;

  assign src_vec = {pll_clk, ref_clk};

  cksw_rsync #(.STAGES(2)) u_rs (.clk(clk), .rst_n(rst_n), .rst_n_sync(bus_rst_n));

  cksw_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .safe_req(safe_req),
    .ack_ref(ack_vec[0]), .ack_pll(ack_vec[1]),
    .want_ref(want_vec[0]), .want_pll(want_vec[1]),
    .div_run(div_run), .act_div(act_div)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    cksw_gate #(.SYNC(SYNC)) u_gate (
      .clk(clk), .bus_rst_n(bus_rst_n), .src_clk(src_vec[g]), .rst_n(rst_n),
      .want(want_vec[g]), .gclk(gclk_vec[g]), .ack(ack_vec[g])
    );
  end

  assign mclk = |gclk_vec;

  cksw_hdiv #(.DW(DIV_W)) u_div (
    .mclk(mclk), .clr_n(bus_rst_n & div_run), .hval(act_div), .clk_out(cpu_clk)
  );
endmodule

// File: tb/sim_cpuclk_mux_div.sv
`timescale 1ns/100ps
module sim_cpuclk_mux_div;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 4;
  localparam int PLL_HALF   = 3;
  localparam logic [11:0] CFG = 12'h050;

  logic clk = 0, ref_clk = 0, pll_clk = 0;
  logic rst_n, safe_req, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic cpu_clk;
  int total = 0, bad = 0;
  int short_cnt = 0;
  logic mon_on = 0;
  time t_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(REF_HALF) ref_clk = ~ref_clk;
  always #(PLL_HALF) pll_clk = ~pll_clk;

  cpuclk_mux_div u0 (.clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk),
    .safe_req(safe_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_clk(cpu_clk));

  // R10: pulse-width monitor
  always @(cpu_clk) begin
    if (mon_on && ($time - t_last) < PLL_HALF) short_cnt++;
    t_last = $time;
  end

  function automatic int half_of(int src);
    return (src == 5) ? PLL_HALF : REF_HALF;
  endfunction
  function automatic int exp_per(int src, int h);
    int n = ((h == 0) ? 1 : h) + 1;
    return n * half_of(src);
  endfunction
  function automatic int exp_hi(int src, int h);
    int n = ((h == 0) ? 1 : h) + 1;
    return (n / 2) * half_of(src);
  endfunction
  function automatic logic [31:0] word(int src, int h);
    return (32'(src) << 8) | 32'(h);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 600; i++) begin
      rd(CFG, d);
      if (!d[31]) return;
    end
  endtask

  task automatic measure(output int per, output int hi);
    int r1 = -1, r2 = -1, f1 = -1, rc = 0;
    logic prev;
    per = -1; hi = -1;
    #0.5; prev = cpu_clk;
    for (int n = 1; n <= 1200 && r2 < 0; n++) begin
      #1;
      if (!prev && cpu_clk) begin
        rc++;
        if (rc == 2) r1 = n;
        if (rc == 3) r2 = n;
      end
      if (prev && !cpu_clk && rc == 2 && f1 < 0) f1 = n;
      prev = cpu_clk;
    end
    if (r2 >= 0) begin per = r2 - r1; hi = f1 - r1; end
  endtask

  task automatic apply_check(string tag, int src, int h);
    logic [31:0] d;
    int per, hi;
    wr(CFG, word(src, h));
    rd(CFG, d);
    chk({tag, " R6 busy set"}, d[31], 1);
    wait_idle();
    rd(CFG, d);
    chk({tag, " R3 readback"}, d & 32'h8000071F, word(src, h));
    measure(per, hi);
    chk({tag, " R4/R5 period"}, per, exp_per(src, h));
    chk({tag, " R4 high time"}, hi, exp_hi(src, h));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int per, hi;
    void'($urandom(32'd20161));
    rst_n = 0; safe_req = 0; bus_wr = 0; bus_addr = CFG; bus_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    rd(CFG, d);
    chk("R1 reset fields", d & 32'h0000071F, word(4, 3));
    wait_idle();
    mon_on = 1;
    measure(per, hi);
    chk("R1 reset period", per, 2 * 2 * REF_HALF);
    chk("R1 reset high", hi, 2 * REF_HALF);
    rd(CFG, d);
    chk("R3 other bits zero", d & ~32'h8000071F, 0);

    apply_check("R5 pll div1", 5, 1);
    apply_check("R4 H0 bypass", 4, 0);
    apply_check("R4 H31 pll", 5, 31);
    apply_check("R4 H2 ref", 4, 2);

    for (int i = 0; i < 10; i++) begin
      int s = ($urandom % 2) ? 5 : 4;
      int h = $urandom % 32;
      apply_check("rand", s, h);
    end

    // R2: other offsets
    apply_check("R2 base", 5, 6);
    wr(12'h054, word(4, 9));
    repeat (4) @(negedge clk);
    rd(CFG, d);
    chk("R2 foreign write ignored", d, word(5, 6));
    rd(12'h054, d);
    chk("R2 foreign read zero", d, 0);
    measure(per, hi);
    chk("R2 output unchanged", per, exp_per(5, 6));

    // R7: back-to-back writes
    wr(CFG, word(5, 5));
    wr(CFG, word(4, 6));
    wait_idle();
    rd(CFG, d);
    chk("R7 latest applied", d, word(4, 6));
    measure(per, hi);
    chk("R7 period", per, exp_per(4, 6));
    chk("R7 high", hi, exp_hi(4, 6));

    // R8: invalid source code
    wr(CFG, word(2, 9));
    wait_idle();
    rd(CFG, d);
    chk("R8 readback unchanged", d, word(4, 6));
    measure(per, hi);
    chk("R8 no edges", per, -1);
    chk("R8 output low", cpu_clk, 0);
    apply_check("R8 restart", 5, 4);

    // R9: safe request
    apply_check("R9 pre", 5, 8);
    @(negedge clk); safe_req = 1;
    rd(CFG, d);
    chk("R9 busy on safe", d[31], 1);
    wait_idle();
    rd(CFG, d);
    chk("R9 safe fields", d, word(4, 3));
    wr(CFG, word(5, 2));
    repeat (4) @(negedge clk);
    rd(CFG, d);
    chk("R9 write ignored", d, word(4, 3));
    measure(per, hi);
    chk("R9 safe period", per, exp_per(4, 3));
    @(negedge clk); safe_req = 0;
    repeat (20) @(negedge clk);
    rd(CFG, d);
    chk("R9 safe kept", d, word(4, 3));
    measure(per, hi);
    chk("R9 safe kept period", per, exp_per(4, 3));
    apply_check("R9 restore", 5, 2);

    chk("R10 short pulses", short_cnt, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule